// File: doc/BRIEF.md
# Programmable Eight-Input Priority Interrupt Controller

The block collects up to eight interrupt request lines, latches their rising edges into a request register and chooses one to present to a processor. A mask register hides individual lines. An in-service register records requests that have been granted and not yet closed. Priority runs in a circle that starts just after a programmable lowest-priority pin. The pointer can be moved explicitly or rotated automatically whenever a request is closed, so every line gets a fair turn.

Software reaches the block through a synchronous byte port with two addresses. Address 0 is the command port and address 1 is the data port. A four-byte initialization sequence sets the vector base and the operating mode. After that, operation commands load the mask, close in-service entries, move the priority pointer, choose which register a command-port read returns, and arm a one-shot poll.

The processor sees a single interrupt output. It answers with an acknowledge that carries the granted pin number. The block also drives a vector, formed from the base and the chosen pin, for the processor to fetch. When the block is instantiated as the master of a cascade, a special nesting mode lets a second request on the cascade pin get through while an earlier request on that pin is still in service.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset the interrupt output and the error flag are low, the block is not ready, and reads of both ports return 0. The lowest-priority pointer starts at 7.
- R2: A command write with bit 4 set starts initialization. The next three data writes are taken in turn as the vector base (the value ANDed with 0xF8), a cascade byte that is ignored, and a mode byte. The mode byte's bit 0 must be 1; its bit 1 enables automatic EOI and its bit 4 enables special nesting. An accepted mode byte makes the block ready.
- R3: `cfgErr` pulses for one cycle, in the cycle after the write, in three cases. An init command with bit 1 set or bit 0 clear: the block stays not ready and further data writes load the mask. A mode byte with bit 0 clear: the block keeps waiting for a mode byte. A command with bit 3 set and bit 6 set: no effect.
- R4: Request inputs are ignored while the block is not ready. Once it is ready, a rising edge on an input sets the matching request bit on the following clock.
- R5: The scan visits pins starting at (pointer+1) mod 8 and wraps through all eight. It skips masked requests and stops with no result at the first pin whose in-service bit is set. `vectorOut` is base OR chosen pin; with no result it is base OR 7.
- R6: One cycle after an eligible request is found, `intrOut` rises. It stays high until an acknowledge or a poll grant, which clear it on the next clock. No new request is signalled while it is high.
- R7: An acknowledge of pin p sets in-service bit p, unless automatic EOI is on. The request bit p is cleared only if input p is low at that moment.
- R8: With automatic EOI, an acknowledge sets no in-service bit. If rotation is on, the pointer becomes the acknowledged pin.
- R9: A command with bit 3 and bit 4 clear is a priority/EOI command, and its bit 7 sets the rotate mode. With bit 5 set, it clears one in-service bit: the pin in bits 2:0 if bit 6 is set, otherwise the highest-priority in-service pin. In rotate mode the pointer then moves to that pin. With bit 5 clear and bits 6 and 7 set, the pointer is loaded from bits 2:0.
- R10: While ready, data writes load the mask and data reads return the mask. A command with bit 3 set, bit 4 clear and bit 1 set chooses the register a command-port read returns: bit 0 = 1 gives in-service, bit 0 = 0 gives request. Bit 2 of the same command arms a poll.
- R11: The read that follows an armed poll disarms it. If a pin is eligible, that read returns 0x80 OR the pin and grants the pin exactly as an acknowledge would. Otherwise the read returns 0x00.
- R12: On a master with special nesting enabled, in-service bit 2 is ignored by the scan.
- R13: An init command clears the mask, sets the pointer to 7, chooses the request register for command reads, and cancels an armed poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Interrupt request lines, one per pin |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe (a poll read has side effects) |
| portSel | input | 1 | 0 = command port, 1 = data port |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid in the cycle `rdEn` is high |
| ackValid | input | 1 | Interrupt acknowledge |
| ackPin | input | 3 | Pin granted by the acknowledge |
| intrOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 8 | Base OR chosen pin, or base OR 7 when none |
| cfgErr | output | 1 | One-cycle pulse on an unsupported command |

## Verification
Assertions watch several cycle-local rules on every clock:
- the interrupt output holds until a grant;
- an acknowledge sets in-service, or leaves in-service unchanged under automatic EOI;
- nothing enters the request register while the block is not ready;
- a poll read disarms the poll;
- a masked pin is never chosen;
- a bad init byte raises the error flag.

The circular priority order, blocking at in-service pins, pointer rotation after EOI or automatic EOI, special nesting, and the values returned by reads only show up over sequences. The bench's scenarios cover these, and a reference model steps alongside the design under random stimulus.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_PINS = 8;
  localparam int PIN_W = $clog2(NUM_PINS);

  // bit positions that select command types; the decode depends on them
  localparam int INIT_SEL_BIT = 4;
  localparam int READSEL_BIT = 3;

  typedef enum logic [1:0] {
    STEP_OPER,
    STEP_BASE,
    STEP_CASC,
    STEP_MODE
  } icw_step_e;

  typedef struct packed {
    logic       initCmd;
    logic       ldBase;
    logic       ldMode;
    logic       ldMask;
    logic       wrRotate;
    logic       eoi;
    logic       eoiSpecific;
    logic       setLowPrio;
    logic       wrReadSel;
    logic [7:0] val;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         portSel,
  input  logic [7:0]   wrData,
  output ctrl_strobe_t strobe,
  output logic         ready,
  output logic         cfgErr
);
  icw_step_e step;
  logic errNow;
  logic modeOk;

  always_comb begin
    strobe = '0;
    strobe.val = wrData;
    errNow = 1'b0;
    modeOk = 1'b0;
    if (wrEn) begin
      if (!portSel) begin
        if (wrData[INIT_SEL_BIT]) begin
          strobe.initCmd = 1'b1;
          errNow = wrData[1] | ~wrData[0];
        end else if (ready) begin
          if (wrData[READSEL_BIT]) begin
            if (wrData[6]) errNow = 1'b1;
            else strobe.wrReadSel = wrData[1];
          end else begin
            strobe.wrRotate = 1'b1;
            if (wrData[5]) begin
              strobe.eoi = 1'b1;
              strobe.eoiSpecific = wrData[6];
            end else begin
              strobe.setLowPrio = wrData[6] & wrData[7];
            end
          end
        end
      end else begin
        unique case (step)
          STEP_BASE: strobe.ldBase = 1'b1;
          STEP_CASC: ;
          STEP_MODE: begin
            modeOk = wrData[0];
            strobe.ldMode = wrData[0];
            errNow = ~wrData[0];
          end
          default: strobe.ldMask = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= STEP_OPER;
      ready <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      cfgErr <= errNow;
      if (strobe.initCmd) begin
        ready <= 1'b0;
        step <= errNow ? STEP_OPER : STEP_BASE;
      end else if (wrEn && portSel) begin
        unique case (step)
          STEP_BASE: step <= STEP_CASC;
          STEP_CASC: step <= STEP_MODE;
          STEP_MODE: if (modeOk) begin
            step <= STEP_OPER;
            ready <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_bad_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !portSel && wrData[INIT_SEL_BIT] && !wrData[0]) |=> (cfgErr && !ready));

  assert_mode_makes_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel && step == STEP_MODE && wrData[0]) |=> ready);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int CASCADE_PIN = 2,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic                ready,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                rdEn,
  input  logic                portSel,
  input  logic                ackValid,
  input  logic [PIN_W-1:0]    ackPin,
  output logic [7:0]          rdData,
  output logic                intrOut,
  output logic [7:0]          vectorOut
);
  logic [NUM_PINS-1:0] irr, isr, mask, irqPrev, isrEff;
  logic [PIN_W-1:0] lowPrio, reqPin, isrPin, acceptPin, eoiPin, idx;
  logic [7:0] base;
  logic aeoi, sfn, rotate, readIsr, pollArmed, raised;
  logic reqFound, isrFound, blocked, pollAccept, accept, eoiHit, rotateNow;

  always_comb begin
    isrEff = isr;
    if (IS_MASTER && sfn) isrEff[CASCADE_PIN] = 1'b0;
    reqFound = 1'b0;
    reqPin = '0;
    isrFound = 1'b0;
    isrPin = '0;
    blocked = 1'b0;
    for (int k = 0; k < NUM_PINS; k++) begin
      idx = lowPrio + PIN_W'(k + 1);
      if (!blocked && !reqFound) begin
        if (isrEff[idx]) blocked = 1'b1;
        else if (irr[idx] && !mask[idx]) begin
          reqFound = 1'b1;
          reqPin = idx;
        end
      end
      if (!isrFound && isr[idx]) begin
        isrFound = 1'b1;
        isrPin = idx;
      end
    end
  end

  assign pollAccept = rdEn && pollArmed && reqFound;
  assign accept = ackValid || pollAccept;
  assign acceptPin = ackValid ? ackPin : reqPin;
  assign eoiPin = strobe.eoiSpecific ? strobe.val[PIN_W-1:0] : isrPin;
  assign eoiHit = strobe.eoi && (strobe.eoiSpecific || isrFound);
  assign rotateNow = strobe.wrRotate ? strobe.val[7] : rotate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr <= '0; isr <= '0; mask <= '0; irqPrev <= '0;
      lowPrio <= PIN_W'(NUM_PINS - 1);
      base <= '0; aeoi <= 1'b0; sfn <= 1'b0; rotate <= 1'b0;
      readIsr <= 1'b0; pollArmed <= 1'b0; raised <= 1'b0;
    end else begin
      irqPrev <= irqIn;
      begin
        logic [NUM_PINS-1:0] irrN, isrN;
        irrN = irr | (ready ? (irqIn & ~irqPrev) : '0);
        isrN = isr;
        if (eoiHit) isrN[eoiPin] = 1'b0;
        if (accept) begin
          if (!irqIn[acceptPin]) irrN[acceptPin] = 1'b0;
          if (!aeoi) isrN[acceptPin] = 1'b1;
        end
        irr <= irrN;
        isr <= isrN;
      end
      if (strobe.initCmd) mask <= '0;
      else if (strobe.ldMask) mask <= strobe.val[NUM_PINS-1:0];
      if (strobe.initCmd) lowPrio <= PIN_W'(NUM_PINS - 1);
      else if (eoiHit && rotateNow) lowPrio <= eoiPin;
      else if (strobe.setLowPrio) lowPrio <= strobe.val[PIN_W-1:0];
      else if (accept && aeoi && rotate) lowPrio <= acceptPin;
      if (strobe.ldBase) base <= {strobe.val[7:3], 3'b000};
      if (strobe.ldMode) begin
        aeoi <= strobe.val[1];
        sfn <= strobe.val[4] & IS_MASTER;
      end
      if (strobe.wrRotate) rotate <= strobe.val[7];
      if (strobe.initCmd) readIsr <= 1'b0;
      else if (strobe.wrReadSel) readIsr <= strobe.val[0];
      if (strobe.initCmd) pollArmed <= 1'b0;
      else if (strobe.wrReadSel) pollArmed <= strobe.val[2];
      else if (rdEn) pollArmed <= 1'b0;
      if (accept) raised <= 1'b0;
      else if (!raised && ready && reqFound) raised <= 1'b1;
    end
  end

  always_comb begin
    if (pollArmed) rdData = reqFound ? (8'h80 | 8'(reqPin)) : 8'h00;
    else if (portSel) rdData = 8'(mask);
    else rdData = readIsr ? 8'(isr) : 8'(irr);
  end

  assign intrOut = raised;
  assign vectorOut = base | (reqFound ? 8'(reqPin) : 8'(NUM_PINS - 1));

  assert_intr_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (raised && !accept) |=> raised);

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !aeoi && !strobe.eoi) |=> isr[$past(ackPin)]);

  assert_aeoi_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && aeoi && !strobe.eoi) |=> $stable(isr));

  assert_not_ready_ignores_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ((irr & ~$past(irr)) == '0));

  assert_poll_oneshot_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && pollArmed && !strobe.wrReadSel) |=> !pollArmed);

  assert_masked_not_chosen_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqFound |-> !mask[reqPin]);
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int CASCADE_PIN = 2,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             portSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             ackValid,
  input  logic [PIN_W-1:0] ackPin,
  output logic             intrOut,
  output logic [7:0]       vectorOut,
  output logic             cfgErr
);
  ctrl_strobe_t strobe;
  logic ready;

  irq_prio_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portSel(portSel), .wrData(wrData),
    .strobe(strobe), .ready(ready), .cfgErr(cfgErr)
  );

  irq_prio_core #(.CASCADE_PIN(CASCADE_PIN), .IS_MASTER(IS_MASTER)) i_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ready(ready), .irqIn(irqIn),
    .rdEn(rdEn), .portSel(portSel), .ackValid(ackValid), .ackPin(ackPin),
    .rdData(rdData), .intrOut(intrOut), .vectorOut(vectorOut)
  );
endmodule

// File: tb/test_irq_prio_unit.sv
`timescale 1ns/1ps
module test_irq_prio_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, portSel = 1'b0, ackValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] ackPin = '0;
  logic [7:0] rdData, vectorOut;
  logic intrOut, cfgErr;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  irq_prio_unit i_irq_prio_unit (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn),
    .portSel(portSel), .wrData(wrData), .rdData(rdData), .ackValid(ackValid),
    .ackPin(ackPin), .intrOut(intrOut), .vectorOut(vectorOut), .cfgErr(cfgErr)
  );

  // reference model state
  logic [7:0] mIrr = '0, mIsr = '0, mMask = '0, mBase = '0, mPrev = '0;
  logic [2:0] mLow = 3'd7;
  logic mAeoi = 0, mSfn = 0, mRot = 0, mRis = 0, mPoll = 0, mRaised = 0;
  logic mReady = 0, mErr = 0;
  int mStep = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] findReq();
    logic [7:0] eff;
    eff = mIsr;
    if (mSfn) eff[2] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] p;
      p = mLow + 3'(k + 1);
      if (eff[p]) return 4'b0;
      if (mIrr[p] && !mMask[p]) return {1'b1, p};
    end
    return 4'b0;
  endfunction

  function automatic logic [3:0] findIsr();
    for (int k = 0; k < 8; k++) begin
      logic [2:0] p;
      p = mLow + 3'(k + 1);
      if (mIsr[p]) return {1'b1, p};
    end
    return 4'b0;
  endfunction

  function automatic logic [7:0] expRd();
    logic [3:0] rq;
    rq = findReq();
    if (mPoll) return rq[3] ? (8'h80 | {5'b0, rq[2:0]}) : 8'h00;
    if (portSel) return mMask;
    return mRis ? mIsr : mIrr;
  endfunction

  // one clock: compare combinational outputs, step the model, compare registered outputs
  task automatic tick(input string tag);
    logic [3:0] rq, iq;
    logic [7:0] nIrr, nIsr, nMask, nBase, d;
    logic [2:0] nLow, ap;
    logic nAeoi, nSfn, nRot, nRis, nPoll, nRaised, nReady, nErr, acc;
    int nStep;
    #2;
    rq = findReq();
    iq = findIsr();
    chk("R5 vectorOut", vectorOut, mBase | (rq[3] ? {5'b0, rq[2:0]} : 8'd7));
    if (rdEn) chk(tag, rdData, expRd());
    acc = ackValid || (rdEn && mPoll && rq[3]);
    ap = ackValid ? ackPin : rq[2:0];
    nIrr = mIrr | (mReady ? (irqIn & ~mPrev) : 8'h00);
    nIsr = mIsr; nMask = mMask; nBase = mBase; nLow = mLow;
    nAeoi = mAeoi; nSfn = mSfn; nRot = mRot; nRis = mRis; nReady = mReady;
    nStep = mStep; nErr = 0;
    nPoll = rdEn ? 1'b0 : mPoll;
    if (acc) begin
      if (!irqIn[ap]) nIrr[ap] = 1'b0;
      if (mAeoi) begin
        if (mRot) nLow = ap;
      end else nIsr[ap] = 1'b1;
    end
    nRaised = acc ? 1'b0 : ((!mRaised && mReady && rq[3]) ? 1'b1 : mRaised);
    d = wrData;
    if (wrEn && !portSel) begin
      if (d[4]) begin
        nMask = 0; nLow = 7; nRis = 0; nPoll = 0; nReady = 0;
        nErr = d[1] | ~d[0];
        nStep = nErr ? 0 : 1;
      end else if (mReady) begin
        if (d[3]) begin
          if (d[6]) nErr = 1;
          else if (d[1]) begin nRis = d[0]; nPoll = d[2]; end
        end else begin
          nRot = d[7];
          if (d[5]) begin
            logic [2:0] ep;
            ep = d[6] ? d[2:0] : iq[2:0];
            if (d[6] || iq[3]) begin
              nIsr[ep] = 1'b0;
              if (nRot) nLow = ep;
            end
          end else if (d[6] && d[7]) nLow = d[2:0];
        end
      end
    end else if (wrEn) begin
      case (mStep)
        1: begin nBase = d & 8'hF8; nStep = 2; end
        2: nStep = 3;
        3: if (d[0]) begin nAeoi = d[1]; nSfn = d[4]; nStep = 0; nReady = 1; end
           else nErr = 1;
        default: nMask = d;
      endcase
    end
    @(posedge clk);
    #1;
    mPrev = irqIn;
    mIrr = nIrr; mIsr = nIsr; mMask = nMask; mBase = nBase; mLow = nLow;
    mAeoi = nAeoi; mSfn = nSfn; mRot = nRot; mRis = nRis; mPoll = nPoll;
    mRaised = nRaised; mReady = nReady; mStep = nStep; mErr = nErr;
    chk("R6 intrOut", intrOut, mRaised);
    chk("R3 cfgErr", cfgErr, mErr);
    @(negedge clk);
  endtask

  task automatic wr(input logic p, input logic [7:0] v);
    wrEn = 1; portSel = p; wrData = v;
    tick("R10 write");
    wrEn = 0;
  endtask

  task automatic rd(input logic p, input string tag);
    rdEn = 1; portSel = p;
    tick(tag);
    rdEn = 0;
  endtask

  task automatic rdExpect(input logic p, input logic [7:0] exp, input string tag);
    rdEn = 1; portSel = p;
    #1 chk(tag, rdData, exp);
    tick(tag);
    rdEn = 0;
  endtask

  task automatic ack(input logic [2:0] p);
    ackValid = 1; ackPin = p;
    tick("R7 ack");
    ackValid = 0;
  endtask

  task automatic pulse(input logic [7:0] bits);
    irqIn = irqIn | bits; tick("R4");
    irqIn = irqIn & ~bits; tick("R4"); tick("R4");
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [3:0] rq;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 intrOut", intrOut, 0);
    chk("R1 cfgErr", cfgErr, 0);
    rdExpect(1, 8'h00, "R1 mask read");
    rdExpect(0, 8'h00, "R1 request read");
    // R4 not ready ignores inputs
    irqIn = 8'h08; tick("R4"); tick("R4");
    rdExpect(0, 8'h00, "R4 ignored before ready");
    irqIn = 0; tick("R4");
    // R3 bad init byte
    wr(0, 8'h10); chk("R3 bad init", cfgErr, 1);
    // R2 init with a rejected mode byte
    wr(0, 8'h11); wr(1, 8'h25); wr(1, 8'h04);
    wr(1, 8'h00); chk("R3 bad mode", cfgErr, 1);
    wr(1, 8'h01);
    chk("R2 base vector", vectorOut, 8'h27);
    wr(1, 8'hF0);
    rdExpect(1, 8'hF0, "R10 mask readback");
    // R4 / R5 masked request captured but not chosen
    irqIn = 8'h20; tick("R4"); tick("R4");
    rdExpect(0, 8'h20, "R4 edge captured");
    chk("R5 masked no intr", intrOut, 0);
    irqIn = 8'h22; tick("R6"); tick("R6");
    chk("R5 vector pin1", vectorOut, 8'h21);
    chk("R6 intr raised", intrOut, 1);
    ack(1);
    chk("R6 ack clears intr", intrOut, 0);
    wr(0, 8'h0B);
    rdExpect(0, 8'h02, "R7 isr after ack");
    wr(0, 8'h0A);
    rdExpect(0, 8'h22, "R7 irr kept while high");
    irqIn = 8'h20; tick("R7");
    wr(0, 8'h20); tick("R6");
    chk("R6 re-raise after eoi", intrOut, 1);
    ack(1);
    rdExpect(0, 8'h20, "R7 irr cleared when low");
    wr(0, 8'h61); wr(0, 8'h0B);
    rdExpect(0, 8'h00, "R9 specific eoi");
    wr(0, 8'h0A);
    // R5 blocking by in-service
    irqIn = 0; tick("R5");
    wr(1, 8'h00); tick("R5");
    chk("R5 vector pin5", vectorOut, 8'h25);
    ack(5);
    pulse(8'h04); ack(2);
    pulse(8'h10);
    chk("R5 blocked vector", vectorOut, 8'h27);
    chk("R5 blocked intr", intrOut, 0);
    pulse(8'h01);
    chk("R5 pin0 above isr", vectorOut, 8'h20);
    ack(0);
    wr(0, 8'h20); wr(0, 8'h0B);
    rdExpect(0, 8'h24, "R9 nonspecific eoi highest");
    wr(0, 8'h0A); wr(0, 8'h20);
    chk("R5 pin4 after eoi", vectorOut, 8'h24);
    ack(4); wr(0, 8'h20); wr(0, 8'h20);
    // R9 rotation
    wr(0, 8'hC4);
    pulse(8'h42);
    chk("R9 set lowprio 4", vectorOut, 8'h26);
    ack(6);
    wr(0, 8'hA0);
    chk("R9 rotate eoi", vectorOut, 8'h21);
    // R11 poll
    wr(0, 8'h0E);
    rdExpect(0, 8'h81, "R11 poll grant");
    wr(0, 8'h0B);
    rdExpect(0, 8'h02, "R11 poll sets isr");
    wr(0, 8'h61);
    wr(0, 8'h0E);
    rdExpect(0, 8'h00, "R11 poll empty");
    wr(0, 8'h00);
    // R13 / R8
    wr(1, 8'h5A); wr(0, 8'h11);
    rdExpect(1, 8'h00, "R13 init clears mask");
    wr(1, 8'h48); wr(1, 8'h00); wr(1, 8'h03);
    chk("R2 new base", vectorOut, 8'h4F);
    wr(0, 8'hC7);
    pulse(8'h08);
    chk("R8 vector pin3", vectorOut, 8'h4B);
    ack(3);
    wr(0, 8'h0B);
    rdExpect(0, 8'h00, "R8 aeoi no isr");
    wr(0, 8'h0A);
    pulse(8'h11);
    chk("R8 lowprio moved to 3", vectorOut, 8'h4C);
    ack(4); tick("R8"); ack(0);
    // R12 special nesting
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h11);
    wr(0, 8'h00);
    pulse(8'h04); ack(2);
    pulse(8'h04);
    chk("R12 cascade re-entry vector", vectorOut, 8'h22);
    chk("R12 cascade re-entry intr", intrOut, 1);
    ack(2); wr(0, 8'h20); wr(0, 8'h20);
    // random phase against the model
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0, 1, 2: begin irqIn = irqIn ^ (8'h01 << ($urandom % 8)); tick("R4"); end
        3: begin
          rq = findReq();
          ack(rq[3] ? rq[2:0] : 3'($urandom % 8));
        end
        4: wr(1, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
        5: wr(0, 8'h20);
        6: begin wr(0, 8'h0A | 8'($urandom % 2)); rd(0, "R10 readback"); end
        7: begin wr(0, 8'h0E); rd(0, "R11 poll"); end
        default: begin
          case ($urandom % 5)
            0: wr(0, 8'h80);
            1: wr(0, 8'h00);
            2: wr(0, 8'hA0);
            3: wr(0, 8'h60 | 8'($urandom % 8));
            default: wr(0, 8'hC0 | 8'($urandom % 8));
          endcase
        end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule